// File: doc/BRIEF.md
# Decoupled-Tag Texel Read Cache

This block is a read-only texel cache built for throughput rather than hit latency. Each texel address is looked up in a direct-mapped tag store in the cycle it is accepted. When the lookup misses, the tag store takes the new line at once and a fill request goes to memory. Every access, hit or miss, then waits in a fragment queue. Entries leave that queue strictly in acceptance order, so a hit never returns before an older miss. This keeps a group of four or eight lookups for one pixel together and in issue order.

Memory may answer fill requests in any order. Each request carries the index of a slot in a fill reorder stage, and a returning fill is parked in that slot. Parked fills are retired oldest-first. A fill is retired only when its own miss reaches the head of the fragment queue, and at that moment it is written into the data store. As a result, the data store always trails the tag store by exactly the set of misses still in the queue. This rule also stops a newer fill from overwriting a line that an older queued hit still has to read. There is no write path.

Top module: `texel_cache`

## Requirements
- R1: After reset, out_valid and mem_req_valid are low, req_ready is high, and every line is invalid, so the first access to any address misses.
- R2: Every accepted address produces exactly one output, in acceptance order. Its out_data equals the word memory returned for that address.
- R3: An access misses when line index addr[5:0] is invalid or holds a different addr[15:6]. A miss issues exactly one memory request carrying the full address, and a hit issues none. The tag is committed at lookup, so a repeat of an address whose fill is still outstanding counts as a hit.
- R4: Memory requests leave in lookup order. Request IDs are reorder-slot indices, handed out round robin from 0 after reset and wrapping at ROB_DEPTH (8). A request that is not taken holds its address and ID.
- R5: Fill responses, matched by ID, are accepted in any order, and the output order and data of R2 still hold.
- R6: A hit accepted behind a miss produces no output until that miss has received its fill and been delivered.
- R7: When a miss evicts a line that an older queued hit still needs, the older hit returns the old line's data, even if the evicting fill arrives first. A later access to the evicted address misses again.
- R8: req_ready goes low while ROB_DEPTH (8) misses await fills, and also while FRAG_DEPTH (16) accesses wait undelivered. No access is accepted beyond those limits.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Texel lookup offered |
| req_ready | output | 1 | Lookup accepted this cycle if valid |
| req_addr | input | ADDR_W | Texel word address |
| mem_req_valid | output | 1 | Fill request pending |
| mem_req_ready | input | 1 | Memory takes the fill request |
| mem_req_addr | output | ADDR_W | Address to fetch |
| mem_req_id | output | ID_W | Reorder slot of the request |
| mem_rsp_valid | input | 1 | Fill response present |
| mem_rsp_id | input | ID_W | Slot the response belongs to |
| mem_rsp_data | input | DATA_W | Fill data |
| out_valid | output | 1 | Texel available for the filter |
| out_ready | input | 1 | Filter takes the texel |
| out_data | output | DATA_W | Texel value |

## Verification
The assertions assume that memory answers each issued ID exactly once, only after the request was taken, and never for a slot with no outstanding request. They also assume that req_valid and the fill signals are sampled as driven from outside, with no combinational path back. The stimulus keeps to this: the responder answers only from its own list of requests already taken, removes each entry once answered, and never answers in the same cycle that it records a new request. Lookups are drawn from a small address range, so conflicting tags in the same line index occur often. Response order is either random or newest-first.

// File: rtl/texc_pkg.sv
package texc_pkg;

   typedef enum logic {
      LK_HIT  = 1'b0,
      LK_MISS = 1'b1
   } lookup_kind_e;

   function automatic int ptr_w(input int depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/texc_fifo.sv
module texc_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int PW = texc_pkg::ptr_w(DEPTH);
   localparam int CW = PW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("texc_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] store_q [DEPTH];
   logic [PW-1:0]    wr_q, rd_q;
   logic [CW-1:0]    cnt_q;

   assign rdata = store_q[rd_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (push) store_q[wr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end
endmodule

// File: rtl/texc_tags.sv
module texc_tags #(
   parameter int ADDR_W = 16,
   parameter int LINES  = 64,
   localparam int IDX_W = $clog2(LINES),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              commit,
   output logic              hit,
   output logic [IDX_W-1:0]  idx
);
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("texc_tags: LINES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("texc_tags: ADDR_W must exceed the index width");
   end

   logic [TAG_W-1:0] tag_q [LINES];
   logic [LINES-1:0] vld_q;
   logic [TAG_W-1:0] lk_tag;

   assign idx    = lk_addr[IDX_W-1:0];
   assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
   assign hit    = vld_q[idx] && (tag_q[idx] == lk_tag);

   always_ff @(posedge clk) begin
      if (commit) tag_q[idx] <= lk_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q      <= '0;
      else if (commit) vld_q[idx] <= 1'b1;
   end
endmodule

// File: rtl/texc_rob.sv
module texc_rob #(
   parameter int DATA_W = 32,
   parameter int LINE_W = 6,
   parameter int DEPTH  = 8,
   localparam int ID_W  = texc_pkg::ptr_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [LINE_W-1:0] alloc_line,
   output logic [ID_W-1:0]   alloc_id,
   output logic              full,
   input  logic              rsp_valid,
   input  logic [ID_W-1:0]   rsp_id,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              head_valid,
   output logic [DATA_W-1:0] head_data,
   output logic [LINE_W-1:0] head_line,
   input  logic              pop
);
   localparam int CW = ID_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("texc_rob: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] data_q [DEPTH];
   logic [LINE_W-1:0] line_q [DEPTH];
   logic [DEPTH-1:0]  filled_q;
   logic [ID_W-1:0]   head_q, tail_q;
   logic [CW-1:0]     cnt_q;

   assign alloc_id   = tail_q;
   assign full       = (cnt_q == CW'(DEPTH));
   assign head_valid = (cnt_q != '0) && filled_q[head_q];
   assign head_data  = data_q[head_q];
   assign head_line  = line_q[head_q];

   always_ff @(posedge clk) begin
      if (alloc)     line_q[tail_q] <= alloc_line;
      if (rsp_valid) data_q[rsp_id] <= rsp_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filled_q <= '0;
         head_q   <= '0;
         tail_q   <= '0;
         cnt_q    <= '0;
      end else begin
         for (int s = 0; s < DEPTH; s++) begin
            if (rsp_valid && rsp_id == ID_W'(s))   filled_q[s] <= 1'b1;
            else if (pop && head_q == ID_W'(s))    filled_q[s] <= 1'b0;
         end
         if (alloc) tail_q <= tail_q + 1'b1;
         if (pop)   head_q <= head_q + 1'b1;
         cnt_q <= cnt_q + CW'(alloc) - CW'(pop);
      end
   end
endmodule

// File: rtl/texel_cache.sv
module texel_cache
   import texc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINES      = 64,
   parameter int FRAG_DEPTH = 16,
   parameter int MISS_DEPTH = 8,
   parameter int ROB_DEPTH  = 8,
   localparam int ID_W      = ptr_w(ROB_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [ID_W-1:0]   mem_req_id,
   input  logic              mem_rsp_valid,
   input  logic [ID_W-1:0]   mem_rsp_id,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int FE_W  = IDX_W + 1;
   localparam int MQ_W  = ADDR_W + ID_W;

   if (DATA_W < 1) begin : g_bad_data
      $error("texel_cache: DATA_W must be positive");
   end

   // lookup stage
   logic             accept, lk_hit, lk_miss;
   logic [IDX_W-1:0] lk_idx;
   logic             frag_full, frag_empty, miss_full, miss_empty, rob_full;

   assign req_ready = !frag_full && !miss_full && !rob_full;
   assign accept    = req_valid && req_ready;
   assign lk_miss   = accept && !lk_hit;

   texc_tags #(.ADDR_W(ADDR_W), .LINES(LINES)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_addr (req_addr),
      .commit  (lk_miss),
      .hit     (lk_hit),
      .idx     (lk_idx)
   );

   // fill reorder stage
   logic [ID_W-1:0]   rob_id;
   logic              rob_head_valid, rob_pop;
   logic [DATA_W-1:0] rob_head_data;
   logic [IDX_W-1:0]  rob_head_line;

   texc_rob #(.DATA_W(DATA_W), .LINE_W(IDX_W), .DEPTH(ROB_DEPTH)) u_rob (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (lk_miss),
      .alloc_line (lk_idx),
      .alloc_id   (rob_id),
      .full       (rob_full),
      .rsp_valid  (mem_rsp_valid),
      .rsp_id     (mem_rsp_id),
      .rsp_data   (mem_rsp_data),
      .head_valid (rob_head_valid),
      .head_data  (rob_head_data),
      .head_line  (rob_head_line),
      .pop        (rob_pop)
   );

   // miss request queue toward memory
   logic [MQ_W-1:0] mq_head;
   logic            mq_pop;

   assign mem_req_valid = !miss_empty;
   assign mq_pop        = mem_req_valid && mem_req_ready;
   assign mem_req_addr  = mq_head[MQ_W-1:ID_W];
   assign mem_req_id    = mq_head[ID_W-1:0];

   texc_fifo #(.WIDTH(MQ_W), .DEPTH(MISS_DEPTH)) u_missq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lk_miss),
      .wdata ({req_addr, rob_id}),
      .pop   (mq_pop),
      .rdata (mq_head),
      .empty (miss_empty),
      .full  (miss_full)
   );

   // fragment queue: every access, in acceptance order
   logic [FE_W-1:0]  frag_head;
   lookup_kind_e     head_kind, lk_kind;
   logic [IDX_W-1:0] head_idx;
   logic             frag_pop;

   assign lk_kind   = lk_hit ? LK_HIT : LK_MISS;
   assign head_kind = lookup_kind_e'(frag_head[FE_W-1]);
   assign head_idx  = frag_head[IDX_W-1:0];

   texc_fifo #(.WIDTH(FE_W), .DEPTH(FRAG_DEPTH)) u_fragq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .wdata ({lk_kind, lk_idx}),
      .pop   (frag_pop),
      .rdata (frag_head),
      .empty (frag_empty),
      .full  (frag_full)
   );

   // data store: written only when a miss fragment retires
   logic [DATA_W-1:0] line_data_q [LINES];

   assign out_valid = !frag_empty && (head_kind == LK_HIT || rob_head_valid);
   assign out_data  = (head_kind == LK_MISS) ? rob_head_data : line_data_q[head_idx];
   assign frag_pop  = out_valid && out_ready;
   assign rob_pop   = frag_pop && (head_kind == LK_MISS);

   always_ff @(posedge clk) begin
      if (rob_pop) line_data_q[rob_head_line] <= rob_head_data;
   end
endmodule

// File: rtl/texc_chk.sv
module texc_chk #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int FRAG_DEPTH = 16,
   parameter int ROB_DEPTH  = 8,
   parameter int ID_W       = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [ID_W-1:0]   mem_req_id,
   input logic              mem_rsp_valid,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);
   localparam int FW = $clog2(FRAG_DEPTH + 1) + 1;
   localparam int MW = $clog2(ROB_DEPTH + 1) + 1;

   logic [FW-1:0]   frag_cnt_q;
   logic [MW-1:0]   fly_cnt_q;
   logic [ID_W-1:0] id_exp_q;
   logic            acc, ofire, mfire;

   assign acc   = req_valid && req_ready;
   assign ofire = out_valid && out_ready;
   assign mfire = mem_req_valid && mem_req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frag_cnt_q <= '0;
         fly_cnt_q  <= '0;
         id_exp_q   <= '0;
      end else begin
         frag_cnt_q <= frag_cnt_q + FW'(acc) - FW'(ofire);
         fly_cnt_q  <= fly_cnt_q + MW'(mfire) - MW'(mem_rsp_valid);
         if (mfire) id_exp_q <= id_exp_q + 1'b1;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid && !mem_req_valid);

   assert_no_phantom_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> frag_cnt_q != '0);

   assert_id_round_robin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mfire |-> mem_req_id == id_exp_q);

   assert_memreq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_id));

   assert_frag_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frag_cnt_q <= FW'(FRAG_DEPTH));

   assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fly_cnt_q <= MW'(ROB_DEPTH));

   assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind texel_cache texc_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAG_DEPTH(FRAG_DEPTH),
   .ROB_DEPTH(ROB_DEPTH), .ID_W(ID_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_req_id    (mem_req_id),
   .mem_rsp_valid (mem_rsp_valid),
   .out_valid     (out_valid),
   .out_ready     (out_ready),
   .out_data      (out_data)
);

// File: tb/tb_texel_cache.sv
`timescale 1ns/1ps
module tb_texel_cache;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int IW = 3;
   localparam int ROBD = 8;
   localparam int FRAGD = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_ready;
   logic [AW-1:0] req_addr;
   logic          mem_req_valid, mem_req_ready;
   logic [AW-1:0] mem_req_addr;
   logic [IW-1:0] mem_req_id;
   logic          mem_rsp_valid;
   logic [IW-1:0] mem_rsp_id;
   logic [DW-1:0] mem_rsp_data;
   logic          out_valid, out_ready;
   logic [DW-1:0] out_data;

   always #2 clk = ~clk;

   texel_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(64), .FRAG_DEPTH(FRAGD),
                 .MISS_DEPTH(8), .ROB_DEPTH(ROBD)) dut (.*);

   int checks = 0, fails = 0;
   int n_acc = 0, n_out = 0, n_mreq = 0;
   int p_out, p_req, p_mreq, p_rsp, rsp_mode;
   string cur_req = "R2";
   logic [AW-1:0] stim_q[$], exp_q[$], missexp_q[$], pend_addr[$];
   logic [IW-1:0] pend_id[$];
   logic [IW-1:0] exp_id = '0;
   logic [9:0] mtag[64];
   logic       mval[64];
   bit         prev_stall = 0;
   logic [DW-1:0] prev_data;

   function automatic logic [DW-1:0] img(input logic [AW-1:0] a);
      return {a, ~a} ^ 32'hC3A5_1E0F;
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   task automatic step();
      logic [AW-1:0] a;
      @(negedge clk);
      if (prev_stall) begin
         chk(out_valid == 1'b1, "R9", "valid dropped while stalled", 32'(out_valid), 1);
         chk(out_data == prev_data, "R9", "data changed while stalled", out_data, prev_data);
      end
      out_ready  = ($urandom_range(99) < p_out);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
         n_out++;
         if (exp_q.size() == 0) chk(0, cur_req, "output with none expected", out_data, 0);
         else begin
            a = exp_q.pop_front();
            chk(out_data == img(a), cur_req, "texel data", out_data, img(a));
         end
      end
      if (stim_q.size() > 0 && $urandom_range(99) < p_req) begin
         req_valid = 1'b1;
         req_addr  = stim_q[0];
         if (req_ready) begin
            a = stim_q.pop_front();
            exp_q.push_back(a);
            n_acc++;
            if (!(mval[a[5:0]] && mtag[a[5:0]] == a[15:6])) begin
               missexp_q.push_back(a);
               mval[a[5:0]] = 1'b1;
               mtag[a[5:0]] = a[15:6];
            end
         end
      end else req_valid = 1'b0;
      mem_rsp_valid = 1'b0;
      if (rsp_mode != 0 && pend_id.size() > 0 && $urandom_range(99) < p_rsp) begin
         int k;
         k = (rsp_mode == 1) ? $urandom_range(pend_id.size() - 1) : pend_id.size() - 1;
         mem_rsp_valid = 1'b1;
         mem_rsp_id    = pend_id[k];
         mem_rsp_data  = img(pend_addr[k]);
         pend_id.delete(k);
         pend_addr.delete(k);
      end
      mem_req_ready = ($urandom_range(99) < p_mreq);
      if (mem_req_valid && mem_req_ready) begin
         n_mreq++;
         if (missexp_q.size() == 0)
            chk(0, "R3", "memory request for a hit", 32'(mem_req_addr), 0);
         else begin
            a = missexp_q.pop_front();
            chk(mem_req_addr == a, "R3", "miss request address", 32'(mem_req_addr), 32'(a));
         end
         chk(mem_req_id == exp_id, "R4", "request id", 32'(mem_req_id), 32'(exp_id));
         exp_id++;
         pend_id.push_back(mem_req_id);
         pend_addr.push_back(mem_req_addr);
      end
   endtask

   task automatic drain(input string rq);
      int n = 0;
      while ((stim_q.size() + exp_q.size() + missexp_q.size() + pend_id.size()) != 0 && n < 20000) begin
         step();
         n++;
      end
      chk(n < 20000, rq, "queues did not drain", n, 20000);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      int a0, o0, m0;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) begin mval[i] = 1'b0; mtag[i] = '0; end
      rst_n = 1'b0; req_valid = 0; req_addr = '0; mem_req_ready = 0;
      mem_rsp_valid = 0; mem_rsp_id = '0; mem_rsp_data = '0; out_ready = 0;
      p_out = 100; p_req = 100; p_mreq = 100; p_rsp = 100; rsp_mode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle state after reset
      chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
      chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 0);

      // R3 / R6: miss then repeat of same address while fill is withheld
      cur_req = "R3"; m0 = n_mreq; o0 = n_out;
      stim_q.push_back(16'h7000); stim_q.push_back(16'h7000);
      idle(12);
      chk(n_mreq - m0 == 1, "R1", "first access misses once", n_mreq - m0, 1);
      chk(n_out - o0 == 0, "R6", "output before fill", n_out - o0, 0);
      rsp_mode = 2; drain("R3");
      chk(n_out - o0 == 2, "R2", "outputs after release", n_out - o0, 2);

      // R6: hit on loaded line queued behind a new miss
      cur_req = "R6"; rsp_mode = 0; o0 = n_out;
      stim_q.push_back(16'h7001); stim_q.push_back(16'h7000);
      idle(12);
      chk(n_out - o0 == 0, "R6", "hit overtook older miss", n_out - o0, 0);
      chk(out_valid == 1'b0, "R6", "out_valid while miss pending", 32'(out_valid), 0);
      rsp_mode = 2; drain("R6");

      // R7: eviction of a line an older queued hit still needs
      cur_req = "R7"; rsp_mode = 0; m0 = n_mreq;
      stim_q.push_back(16'h0123); stim_q.push_back(16'h0123);
      stim_q.push_back(16'h0163); stim_q.push_back(16'h0123);
      idle(14);
      chk(n_mreq - m0 == 3, "R7", "requests for evict sequence", n_mreq - m0, 3);
      rsp_mode = 2; drain("R7");

      // R8: fill reorder stage full
      cur_req = "R8"; rsp_mode = 0; p_out = 0; a0 = n_acc;
      for (int i = 0; i < 12; i++) stim_q.push_back(16'h4000 + 16'(i));
      idle(30);
      chk(n_acc - a0 == ROBD, "R8", "accepted with fills outstanding", n_acc - a0, ROBD);
      chk(req_ready == 1'b0, "R8", "req_ready with reorder stage full", 32'(req_ready), 0);
      rsp_mode = 1; p_out = 100; drain("R8");

      // R8: fragment queue full with hits only
      for (int i = 0; i < 20; i++) stim_q.push_back(16'h5000 + 16'(i));
      drain("R8");
      p_out = 0; a0 = n_acc;
      for (int i = 0; i < 20; i++) stim_q.push_back(16'h5000 + 16'(i));
      idle(40);
      chk(n_acc - a0 == FRAGD, "R8", "accepted with fragment queue full", n_acc - a0, FRAGD);
      chk(req_ready == 1'b0, "R8", "req_ready with fragment queue full", 32'(req_ready), 0);
      // R9: output stalled for several cycles keeps its value
      chk(out_valid == 1'b1, "R9", "stalled head visible", 32'(out_valid), 1);
      p_out = 100; drain("R8");

      // R5: random traffic, random response order, random handshakes
      cur_req = "R5"; rsp_mode = 1;
      p_out = 70; p_req = 80; p_mreq = 70; p_rsp = 50;
      for (int i = 0; i < 4000; i++) stim_q.push_back(16'($urandom_range(383)));
      drain("R5");
      // R2: same with newest-first responses and full-rate handshakes
      cur_req = "R2"; rsp_mode = 2;
      p_out = 100; p_req = 100; p_mreq = 100; p_rsp = 60;
      for (int i = 0; i < 2000; i++) stim_q.push_back(16'($urandom_range(200)) + 16'h0200);
      drain("R2");
      chk(n_out == n_acc, "R2", "outputs equal accepted", n_out, n_acc);

      summary();
      $finish;
   end
endmodule